// File: doc/BRIEF.md
# Audio Sample Rate Divider with Overflow-Bit Reload

This block divides a 98.304 MHz system clock down to the 44.1 kHz compact-disc audio sample rate. The exact ratio is about 2229.1156. The block uses a fixed ratio of 2229, which gives a frequency error of roughly 52 ppm. In return it adds no jitter beyond the jitter of the input clock.

The core is a synchronous binary counter of `CNT_W` bits, 12 by default. One extra flip-flop above it catches the carry out of the counter. The counter counts up from a preset value. When it wraps, the carry sets the extra bit. On the next clock the whole counter, extra bit included, is loaded again with the preset. No comparison against the divisor is needed. The extra bit is high for one clock per period and serves as a sample strobe inside the chip. The top bit of the regular counter is high for most of each period and is meant for clocking external converters.

The preset value is derived from the parameters as 2^`CNT_W` + 1 − `PERIOD`, which is 1868 by default. A synchronous active-low reset loads the preset.

Top module: `audio_rate_divider`

## Requirements
- R1: While `rst_n` is low at a rising edge, both `sample_strobe` and `rate_clk` are 0 after that edge. The counter then holds the preset, 1868, whose bit 11 is 0.
- R2: Each `sample_strobe` pulse is high for exactly one clock cycle.
- R3: Successive rising edges of `sample_strobe` are exactly `PERIOD` (2229) clock cycles apart.
- R4: After reset is released, `sample_strobe` is first high in the cycle that follows the 2228th rising edge at which `rst_n` is sampled high.
- R5: `rate_clk` is bit `CNT_W-1` (bit 11) of the counter. It is high for 2048 consecutive cycles in every period.
- R6: `rate_clk` is low for 181 consecutive cycles in every period. It falls in the same cycle in which `sample_strobe` rises.
- R7: A reset asserted in the middle of a period clears both outputs and restarts the count. The next strobe then follows the R4 timing again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 98.304 MHz |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset |
| sample_strobe | output | 1 | One-cycle pulse, once per output period |
| rate_clk | output | 1 | Top counter bit; long high phase, same rate as the strobe |

## Verification
The divider is first run from a clean reset through five consecutive periods. This separates the first-strobe latency (R4) from the steady-state spacing (R3), and so catches a preset that is off by one in either direction. Each period also measures the strobe width, the high time of `rate_clk` and its low time. A wrong tap bit or a lost overflow cycle shows up as 2047/182 or as 2228 instead of 2048/181 and 2229. A second pattern asserts reset while `rate_clk` is high, in the middle of a period. This shows that reset clears a partly finished count and that the following strobe keeps the first-strobe timing, not the old phase.

// File: rtl/audrate_pkg.sv
// Package: audrate_pkg
// Shared helpers for the audio rate divider. It computes the reload value
// from the counter width and the wanted period.
// Assumes 2 <= period <= 2**cnt_w, so the reload value fits the regular
// counter bits and the extra bit is always reloaded to 0.
package audrate_pkg;

    // Reload value: the count runs preset .. 2**cnt_w inclusive, which is
    // (2**cnt_w + 1 - preset) states.
    function automatic int preset_for(int cnt_w, int period);
        return (1 << cnt_w) + 1 - period;
    endfunction

    // Cycles from reload until the top regular bit first goes high.
    function automatic int msb_delay_for(int cnt_w, int period);
        return (1 << (cnt_w - 1)) - preset_for(cnt_w, period);
    endfunction

endpackage

// File: rtl/aud_low_counter.sv
// Module: aud_low_counter
// Regular part of the divider counter: a CNT_W-bit synchronous up-counter
// with a synchronous load. It exports its carry-out (all bits set) and its
// top bit.
// Assumes that load is a registered or reset-qualified signal of the same
// clock domain.
module aud_low_counter #(
    parameter int CNT_W  = 12,
    parameter int PRESET = 1868
) (
    input  logic clk,
    input  logic load,
    output logic carry_out,
    output logic msb
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PRESET);

    logic [CNT_W-1:0] cnt;

    // Count up by one each clock, or take the reload value.
    always_ff @(posedge clk) begin
        if (load) begin
            cnt <= LOAD_VAL;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The carry out of the incrementer: the next step wraps to zero.
    always_comb begin
        carry_out = &cnt;
        msb       = cnt[CNT_W-1];
    end
endmodule

// File: rtl/aud_ovf_bit.sv
// Module: aud_ovf_bit
// Extra counter bit above the regular counter. It registers the carry-out,
// so it is high for the single cycle after the regular bits wrap.
// Assumes that load is asserted whenever this bit is high, so it can never
// stay high for two cycles.
module aud_ovf_bit (
    input  logic clk,
    input  logic load,
    input  logic carry_in,
    output logic ovf
);
    // Capture the wrap; on reload the preset puts a zero in this bit.
    always_ff @(posedge clk) begin
        if (load) begin
            ovf <= 1'b0;
        end else begin
            ovf <= carry_in;
        end
    end
endmodule

// File: rtl/audio_rate_divider.sv
// Module: audio_rate_divider
// Divides clk by PERIOD. It uses a CNT_W-bit counter plus an overflow bit.
// The overflow bit triggers a synchronous reload of the preset, so no
// equality compare against the divisor is built.
// Outputs: a one-cycle strobe (the overflow bit) and a long-high rate
// signal (the top regular bit).
// Assumes 2 <= PERIOD <= 2**CNT_W and a synchronous active-low reset.
module audio_rate_divider #(
    parameter int CNT_W  = 12,
    parameter int PERIOD = 2229
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_strobe,
    output logic rate_clk
);
    import audrate_pkg::*;

    localparam int PRESET = preset_for(CNT_W, PERIOD);

    logic load;
    logic carry;
    logic ovf;
    logic msb;

    // Reload on reset or when the overflow state has been reached.
    always_comb begin
        load = !rst_n || ovf;
    end

    aud_low_counter #(
        .CNT_W (CNT_W),
        .PRESET(PRESET)
    ) u_low (
        .clk      (clk),
        .load     (load),
        .carry_out(carry),
        .msb      (msb)
    );

    aud_ovf_bit u_ovf (
        .clk     (clk),
        .load    (load),
        .carry_in(carry),
        .ovf     (ovf)
    );

    // Both outputs are register bits brought out directly.
    always_comb begin
        sample_strobe = ovf;
        rate_clk      = msb;
    end
endmodule

// File: rtl/audio_rate_divider_chk.sv
// Module: audio_rate_divider_chk
// Property checker for audio_rate_divider, attached through bind.
// It keeps its own cycle counter, counted since reset release or since the
// last strobe, to check the period timing without long $past windows.
module audio_rate_divider_chk #(
    parameter int CNT_W  = 12,
    parameter int PERIOD = 2229
) (
    input logic clk,
    input logic rst_n,
    input logic sample_strobe,
    input logic rate_clk
);
    import audrate_pkg::*;

    localparam int GW      = $clog2(PERIOD) + 1;
    localparam int RISE_AT = msb_delay_for(CNT_W, PERIOD);

    logic [GW-1:0] gap;
    logic          was_reset;

    // Cycles since reset release or since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || sample_strobe) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1: after an edge with reset low, both outputs are quiet.
    always_ff @(posedge clk) begin
        if (was_reset) begin
            a_r1_reset_quiet: assert (!sample_strobe && !rate_clk)
                else $error("R1: outputs active after reset edge");
        end
        was_reset <= !rst_n;
    end

    // R2: the strobe lasts one cycle.
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    // R3 / R4: the strobe occurs exactly PERIOD-1 cycles after the count restarts.
    a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe == (gap == GW'(PERIOD - 1)));

    // R5: the top bit rises a fixed number of cycles after the reload.
    a_r5_rate_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rate_clk) && $past(rst_n)) |-> (gap == GW'(RISE_AT)));

    // R6: the top bit falls together with the strobe.
    a_r6_rate_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rate_clk) && $past(rst_n)) |-> sample_strobe);
endmodule

bind audio_rate_divider audio_rate_divider_chk #(
    .CNT_W (CNT_W),
    .PERIOD(PERIOD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_strobe(sample_strobe),
    .rate_clk     (rate_clk)
);

// File: tb/audio_rate_divider_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected measurements and the
// monitor measures them at falling edges and compares.
module audio_rate_divider_test;
    localparam int EXP_PERIOD = 2229;  // R3
    localparam int EXP_FIRST  = 2228;  // R4
    localparam int EXP_HIGH   = 2048;  // R5
    localparam int EXP_LOW    = 181;   // R6

    typedef enum int {EV_FIRST, EV_GAP, EV_HIGH, EV_WIDTH, EV_LOW} ev_t;
    typedef struct {
        ev_t   kind;
        int    value;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_strobe;
    logic rate_clk;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    item_t exp_q[$];

    audio_rate_divider uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_strobe(sample_strobe),
        .rate_clk     (rate_clk)
    );

    always #2.5 clk = ~clk;

    task automatic push(ev_t k, int v, string tag);
        item_t it;
        it.kind = k; it.value = v; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic emit(ev_t k, int v);
        item_t it;
        if (exp_q.size() == 0) begin
            compared++;
            mismatched++;
            $display("FAIL unexpected event %s: actual %0d expected none", k.name(), v);
        end else begin
            it = exp_q.pop_front();
            check(it.kind == k && it.value == v,
                  $sformatf("%s %s (got %s)", it.tag, it.kind.name(), k.name()), v, it.value);
        end
    endtask

    // Monitor: measures strobe and rate timing at each falling edge.
    int n, last, wid, hi_cnt, lo_cnt;
    bit started, seen_fall, prev_s, prev_r;
    always @(negedge clk) begin
        if (!rst_n) begin
            n = 0; last = 0; wid = 0; hi_cnt = 0; lo_cnt = 0;
            started = 0; seen_fall = 0; prev_s = 0; prev_r = 0;
        end else begin
            n++;
            if (sample_strobe && !prev_s) begin
                if (!started) emit(EV_FIRST, n);
                else emit(EV_GAP, n - last);
                started = 1; last = n;
            end
            if (sample_strobe) wid++;
            else if (prev_s) begin emit(EV_WIDTH, wid); wid = 0; end
            if (rate_clk) begin
                if (!prev_r && seen_fall) emit(EV_LOW, lo_cnt);
                hi_cnt++;
            end else begin
                if (prev_r) begin
                    emit(EV_HIGH, hi_cnt); hi_cnt = 0; seen_fall = 1; lo_cnt = 0;
                end
                lo_cnt++;
            end
            prev_s = sample_strobe;
            prev_r = rate_clk;
        end
    end

    task automatic wait_drained();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver: reset, steady run, reset in mid-period, second run.
    initial begin
        repeat (4) @(negedge clk);
        check(sample_strobe == 1'b0, "R1 strobe in reset", int'(sample_strobe), 0);
        check(rate_clk == 1'b0, "R1 rate in reset", int'(rate_clk), 0);

        push(EV_FIRST, EXP_FIRST, "R4");
        for (int k = 0; k < 4; k++) begin
            push(EV_HIGH, EXP_HIGH, "R5");
            push(EV_WIDTH, 1, "R2");
            push(EV_LOW, EXP_LOW, "R6");
            push(EV_GAP, EXP_PERIOD, "R3");
        end
        push(EV_HIGH, EXP_HIGH, "R5");
        push(EV_WIDTH, 1, "R2");
        push(EV_LOW, EXP_LOW, "R6");
        #1 rst_n = 1'b1;
        wait_drained();

        repeat (300) @(negedge clk);
        check(rate_clk == 1'b1, "R5 rate high mid-period", int'(rate_clk), 1);
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sample_strobe == 1'b0, "R7 strobe after mid reset", int'(sample_strobe), 0);
        check(rate_clk == 1'b0, "R7 rate after mid reset", int'(rate_clk), 0);

        push(EV_FIRST, EXP_FIRST, "R7");
        push(EV_HIGH, EXP_HIGH, "R5");
        push(EV_WIDTH, 1, "R2");
        push(EV_LOW, EXP_LOW, "R6");
        push(EV_GAP, EXP_PERIOD, "R7");
        push(EV_HIGH, EXP_HIGH, "R5");
        push(EV_WIDTH, 1, "R2");
        #1 rst_n = 1'b1;
        wait_drained();
        repeat (20) @(negedge clk);
        report();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (60000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d items pending expected 0", exp_q.size());
        report();
    end
endmodule